// File: doc/BRIEF.md
# Twisted-Ring Reseeding Pattern Generator

This block turns the n-bit input register of a circuit under test into a test-per-clock pattern source. A seed is shifted into the register one bit at a time. The seed can come from a small on-chip store or from a slower external tester, which may pause between bits. Once the seed is complete, the register runs on its own.

For each seed the register runs n rounds. In each round it first steps 2n times as a Johnson counter, with the inverted top bit fed back into the bottom bit. It then makes one plain rotation. This gives 2n²+n patterns per seed, one on every clock cycle outside loading.

A start pulse and a seed count set how many seeds are consumed. After the last seed, a done flag rises and the register freezes.

Top module: `trc_pattern_gen`

## Requirements
- R1: After reset, `pattern_valid`, `done`, `seed_ready` and `seed_req` are all low.
- R2: `seed_ready` is high only while a seed is being loaded. On each clock where `seed_valid` and `seed_ready` are both high, the pattern register becomes `{pattern[WIDTH-2:0], seed_bit}`, so the first bit sent ends up in the MSB. A loading cycle without `seed_valid` leaves `pattern` unchanged. After WIDTH accepted bits, the next cycle presents the seed itself with `pattern_valid` high.
- R3: `seed_req` is high from the start of each seed load until the first bit of that seed is accepted, and low after that.
- R4: During a twist step, the next pattern is `{pattern[WIDTH-2:0], ~pattern[WIDTH-1]}`. Twist steps come in runs of exactly 2*WIDTH.
- R5: Each run of twist steps is followed by exactly one rotation step, whose next pattern is `{pattern[WIDTH-2:0], pattern[WIDTH-1]}`. The cycle after a rotation starts a new twist run, unless that rotation was the WIDTH-th one for the seed.
- R6: Each seed yields exactly 2*WIDTH²+WIDTH consecutive cycles with `pattern_valid` high. `pattern_valid` is low during loading.
- R7: After `seed_total` seeds, `done` rises and `pattern_valid` falls in the cycle after the final rotation. While `start` stays low, `done` stays high and `pattern` holds its value.
- R8: `start` has no effect while a run is in progress. `start` with `seed_total` equal to 0 loads nothing: `seed_ready` and `pattern_valid` stay low and `done` ends high. `start` with a nonzero count clears `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when no run is in progress |
| seed_total | input | SEED_CNT_W | Number of seeds for the run, captured at start |
| seed_bit | input | 1 | Serial seed data |
| seed_valid | input | 1 | `seed_bit` is valid |
| seed_ready | output | 1 | Register is accepting seed bits |
| seed_req | output | 1 | A new seed is wanted; no bit of it accepted yet |
| pattern | output | WIDTH | Pattern applied to the circuit under test |
| pattern_valid | output | 1 | `pattern` is a test pattern this cycle |
| done | output | 1 | All seeds of the run are processed |

## Verification
Two events can fall in the same cycle: a `start` pulse and the final rotation of the last seed, the cycle where the generator finishes its work. The bench counts the patterns a scoreboard has seen in the current seed and raises `start` exactly in that final pattern cycle. It then requires that `done` rises, `pattern_valid` falls, and no new load begins. Seed-bit stalls are also placed across the first accepted bit, so that the request flag and the load counter are judged in the same window. Every pattern is compared against a queue filled from the twist and rotate rules.

// File: rtl/trc_pattern_gen.sv
module trc_pattern_gen #(
  parameter int WIDTH      = 8,
  parameter int SEED_CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [SEED_CNT_W-1:0] seed_total,
  input  logic                  seed_bit,
  input  logic                  seed_valid,
  output logic                  seed_ready,
  output logic                  seed_req,
  output logic [WIDTH-1:0]      pattern,
  output logic                  pattern_valid,
  output logic                  done
);
  localparam int CW = $clog2(WIDTH);
  localparam int TW = $clog2(2 * WIDTH);
  localparam logic [CW-1:0] LAST_BIT   = CW'(WIDTH - 1);
  localparam logic [TW-1:0] LAST_TWIST = TW'(2 * WIDTH - 2);

  typedef enum logic [1:0] {
    S_LOAD  = 2'b00,
    S_TW1   = 2'b01,
    S_TW2   = 2'b10,
    S_SHIFT = 2'b11
  } state_t;

  state_t                st;
  logic                  running, done_q;
  logic [WIDTH-1:0]      pat;
  logic [CW-1:0]         ld_cnt, sh_cnt;
  logic [TW-1:0]         tw_cnt;
  logic [SEED_CNT_W-1:0] seed_cnt, total_q;

  wire [WIDTH-1:0] twisted = {pat[WIDTH-2:0], ~pat[WIDTH-1]};
  wire [WIDTH-1:0] rotated = {pat[WIDTH-2:0], pat[WIDTH-1]};
  wire             last_seed = (seed_cnt == SEED_CNT_W'(total_q - 1'b1));

  assign seed_ready    = running && st == S_LOAD;
  assign seed_req      = seed_ready && ld_cnt == '0;
  assign pattern_valid = running && st != S_LOAD;
  assign pattern       = pat;
  assign done          = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_LOAD;
      running  <= 1'b0;
      done_q   <= 1'b0;
      pat      <= '0;
      ld_cnt   <= '0;
      sh_cnt   <= '0;
      tw_cnt   <= '0;
      seed_cnt <= '0;
      total_q  <= '0;
    end else if (!running) begin
      if (start) begin
        total_q  <= seed_total;
        done_q   <= (seed_total == '0);
        running  <= (seed_total != '0);
        st       <= S_LOAD;
        ld_cnt   <= '0;
        seed_cnt <= '0;
      end
    end else begin
      case (st)
        S_LOAD: if (seed_valid) begin
          pat <= {pat[WIDTH-2:0], seed_bit};
          if (ld_cnt == LAST_BIT) begin
            ld_cnt <= '0;
            sh_cnt <= '0;
            st     <= S_TW1;
          end else begin
            ld_cnt <= ld_cnt + 1'b1;
          end
        end
        S_TW1: begin
          pat    <= twisted;
          tw_cnt <= '0;
          st     <= S_TW2;
        end
        S_TW2: begin
          pat    <= twisted;
          tw_cnt <= tw_cnt + 1'b1;
          if (tw_cnt == LAST_TWIST) st <= S_SHIFT;
        end
        S_SHIFT: begin
          pat <= rotated;
          if (sh_cnt == LAST_BIT) begin
            sh_cnt <= '0;
            st     <= S_LOAD;
            if (last_seed) begin
              running <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              seed_cnt <= seed_cnt + 1'b1;
            end
          end else begin
            sh_cnt <= sh_cnt + 1'b1;
            st     <= S_TW1;
          end
        end
        default: st <= S_LOAD;
      endcase
    end
  end

  // R2
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ready && !seed_valid |=> $stable(pattern));
  // R3
  req_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_req |-> seed_ready && !pattern_valid);
  // R4
  twist_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && (st == S_TW1 || st == S_TW2) |=>
      pattern == {$past(pattern[WIDTH-2:0]), ~$past(pattern[WIDTH-1])});
  // R5
  rot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && st == S_SHIFT |=>
      pattern == {$past(pattern[WIDTH-2:0]), $past(pattern[WIDTH-1])});
  // R6
  no_pv_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ready |-> !pattern_valid);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(pattern) && !pattern_valid);
endmodule

// File: tb/trc_pattern_gen_bench.sv
module trc_pattern_gen_bench;
  localparam int W   = 5;
  localparam int SW  = 4;
  localparam int PER = 2 * W * W + W;

  logic clk = 0, rst_n = 0, start = 0, seed_bit = 0, seed_valid = 0;
  logic [SW-1:0] seed_total = '0;
  logic seed_ready, seed_req, pattern_valid, done;
  logic [W-1:0] pattern;

  int checks = 0, failures = 0, run_len = 0;
  logic [W-1:0] exp_q[$];

  always #2 clk = ~clk;

  trc_pattern_gen #(.WIDTH(W), .SEED_CNT_W(SW)) u_trc_pattern_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_total(seed_total),
    .seed_bit(seed_bit), .seed_valid(seed_valid), .seed_ready(seed_ready),
    .seed_req(seed_req), .pattern(pattern), .pattern_valid(pattern_valid),
    .done(done));

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: R4 R5 pattern values, R6 run length
  always @(negedge clk) begin
    if (rst_n && pattern_valid) begin
      run_len++;
      if (exp_q.size() == 0) check(1'b0, "R4/R5 unexpected pattern", 32'(pattern), 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(pattern == e, "R4/R5 pattern", 32'(pattern), 32'(e));
      end
    end else if (run_len != 0) begin
      check(run_len == PER, "R6 patterns per seed", run_len, PER);
      run_len = 0;
    end
  end

  // driver: push expected sequence then feed seed bits MSB first
  task automatic run_seed(input logic [W-1:0] s, input int stall);
    logic [W-1:0] p;
    p = s;
    for (int r = 0; r < W; r++) begin
      for (int t = 0; t < 2 * W; t++) begin
        exp_q.push_back(p);
        p = {p[W-2:0], ~p[W-1]};
      end
      exp_q.push_back(p);
      p = {p[W-2:0], p[W-1]};
    end
    @(negedge clk);
    while (!seed_ready) @(negedge clk);
    check(seed_req == 1'b1, "R3 request before first bit", 32'(seed_req), 1);
    for (int i = W - 1; i >= 0; i--) begin
      for (int k = 0; k < stall; k++) begin
        seed_valid = 0;
        @(negedge clk);
        if (i == W - 2) check(seed_req == 1'b0, "R3 request drops after first bit", 32'(seed_req), 0);
        if (i == W - 2) check(pattern[0] == s[W-1], "R2 stall keeps bit", 32'(pattern[0]), 32'(s[W-1]));
      end
      seed_valid = 1;
      seed_bit = s[i];
      @(negedge clk);
    end
    seed_valid = 0;
    check(pattern_valid && pattern == s, "R2 seed loaded", 32'(pattern), 32'(s));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(!pattern_valid && !done && !seed_ready && !seed_req, "R1 reset state",
              {pattern_valid, done, seed_ready, seed_req}, 0);
        rst_n = 1;
        seed_total = 2;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        run_seed(5'b10110, 0);
        run_seed(5'b00011, 2);
        while (run_len != PER) begin @(negedge clk); #1; end
        start = 1;
        @(negedge clk); start = 0;
        check(done == 1'b1, "R7 done after last seed", 32'(done), 1);
        check(!pattern_valid && !seed_ready, "R8 start ignored while running",
              {pattern_valid, seed_ready}, 0);
        begin
          logic [W-1:0] held;
          held = pattern;
          repeat (6) @(negedge clk);
          check(done && pattern == held && !pattern_valid, "R7 hold after done",
                32'(pattern), 32'(held));
        end
        seed_total = 0;
        start = 1;
        @(negedge clk); start = 0;
        repeat (4) @(negedge clk);
        check(done && !seed_ready && !pattern_valid, "R8 zero seed count",
              {done, seed_ready, pattern_valid}, 3'b100);
        seed_total = 1;
        start = 1;
        @(negedge clk); start = 0;
        check(!done && seed_ready, "R8 restart clears done", {done, seed_ready}, 2'b01);
        run_seed(5'b11111, 1);
        while (!done) @(negedge clk);
        check(!pattern_valid, "R7 valid low at done", 32'(pattern_valid), 0);
        check(exp_q.size() == 0, "R6 all patterns seen", exp_q.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule